// File: doc/BRIEF.md
# Privileged Physical Range Guard

This block sits on a core's memory request path, between the request port and the cache/memory pipeline. It guards one physical address window that is described by a base/mask register pair. For each request it takes the physical address, the read/write direction, a privileged-mode flag and the memory type already chosen by the general range logic. From these it decides whether the request may go downstream. It also decides which memory type applies and what read data the core sees.

Inside the window and in privileged mode, the access goes ahead with the memory type held in the base register. That type takes precedence over whatever the general range logic proposed. Outside privileged mode, a read in the window never reaches memory and returns all-ones data. A write in the window is dropped. In both cases the reported type is uncacheable. Addresses outside the window pass through untouched. The two guard registers can only be changed while the privileged flag is set. A fixed capability register tells software that the guard exists.

The decision path is purely combinational. Only the register file holds state.

Top module: `prot_range_filter`

## Requirements
- R1: After reset both guard registers read as zero, so the window is disabled and every request is forwarded with the general memory type.
- R2: A request hits the window when the mask valid bit (bit 11 of the mask register) is set and, for every address bit from bit 12 up to the top physical bit, the bit is either masked off or equal to the corresponding base bit. Address bits 11:0 play no part.
- R3: A valid request that hits while the privileged flag is set is forwarded, is not blocked, and reports the base register's type field (bits 7:0) in place of the general memory type. The response data is the memory data.
- R4: A valid read that hits while the privileged flag is clear is blocked and not forwarded. Its response data is all ones and its reported type is 0 (uncacheable).
- R5: A valid write that hits while the privileged flag is clear is blocked, not forwarded, and reports type 0. When req_valid is low, nothing is forwarded or blocked.
- R6: A valid request that misses the window is forwarded unblocked. It carries the general memory type unchanged and the memory read data, in either privilege state.
- R7: A register write with reg_wr_en high and the privileged flag set updates the selected register on that clock edge. Readback on reg_rdata is combinational from the stored value. Select codes: 0 = base, 1 = mask, 2 = capability, 3 = none.
- R8: A register write presented while the privileged flag is clear leaves both guard registers unchanged.
- R9: The capability register (select 2) always reads 64'h800, with bit 11 set and all other bits clear. Writes to it, and to select 3, change nothing. Select 3 reads zero.
- R10: With the mask valid bit clear, no address hits, whatever the base and mask address fields hold.
- R11: Only implemented fields are stored. Base keeps bits 7:0 and bits PA_W-1:12. Mask keeps bit 11 and bits PA_W-1:12. Every other bit reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_mode | input | 1 | Core is in privileged mode |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | PA_W | Physical address of request |
| gen_mtype | input | 8 | Memory type from general range logic |
| mem_rdata | input | DATA_W | Read data returned by memory path |
| fwd_valid | output | 1 | Request may proceed downstream |
| blocked | output | 1 | Request was stopped by the guard |
| in_range | output | 1 | Address hits the enabled window |
| out_mtype | output | 8 | Resolved memory type |
| rsp_rdata | output | DATA_W | Read data returned to the core |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for read and write |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Selected register value |

## Verification
Every access-path result (fwd_valid, blocked, in_range, out_mtype, rsp_rdata) is combinational, so it is due in the same cycle as its request. The bench drives each request just after a falling edge and samples a couple of time units later, before the next rising edge. A register write takes effect on the first rising edge that sees it. The bench therefore reads the old value before that edge and the new value just after it, and this pins the one-edge latency. Blocked-write checks are made at fwd_valid itself, which is the only way a write could reach memory.

// File: rtl/prot_range_pkg.sv
package prot_range_pkg;

    localparam int REG_W     = 64;
    localparam int PAGE_LSB  = 12;
    localparam int VALID_BIT = 11;
    localparam int CAP_BIT   = 11;
    localparam int MT_W      = 8;

    // memory type encodings
    localparam logic [MT_W-1:0] MT_UC = 8'd0;
    localparam logic [MT_W-1:0] MT_WC = 8'd1;
    localparam logic [MT_W-1:0] MT_WT = 8'd4;
    localparam logic [MT_W-1:0] MT_WP = 8'd5;
    localparam logic [MT_W-1:0] MT_WB = 8'd6;

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_CAP  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic valid;
        logic write;
        logic priv;
        logic hit;
    } acc_ctx_t;

    typedef struct packed {
        logic            fwd;
        logic            blocked;
        logic            subst;
        logic [MT_W-1:0] mtype;
    } acc_dec_t;

    function automatic logic [REG_W-1:0] cap_value();
        logic [REG_W-1:0] v;
        v          = '0;
        v[CAP_BIT] = 1'b1;
        return v;
    endfunction

    function automatic acc_dec_t decide(input acc_ctx_t c,
                                        input logic [MT_W-1:0] gen_mt,
                                        input logic [MT_W-1:0] win_mt);
        acc_dec_t d;
        d.fwd     = c.valid;
        d.blocked = 1'b0;
        d.subst   = 1'b0;
        d.mtype   = gen_mt;
        if (c.hit) begin
            if (c.priv) begin
                d.mtype = win_mt;
            end else begin
                d.mtype   = MT_UC;
                d.fwd     = 1'b0;
                d.blocked = c.valid;
                d.subst   = c.valid & ~c.write;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/prot_range_regs.sv
module prot_range_regs
    import prot_range_pkg::*;
#(
    parameter int PA_W = 36
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  priv_mode,
    input  logic                  wr_en,
    input  logic [1:0]            sel,
    input  logic [REG_W-1:0]      wdata,
    output logic [REG_W-1:0]      rdata,
    output logic [PA_W-PAGE_LSB-1:0] base_page,
    output logic [MT_W-1:0]       base_type,
    output logic [PA_W-PAGE_LSB-1:0] mask_page,
    output logic                  mask_vld
);
    localparam int PG_W = PA_W - PAGE_LSB;

    logic wr_ok;
    logic unused_wdata;

    assign wr_ok        = wr_en & priv_mode;
    assign unused_wdata = ^wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_page <= '0;
            base_type <= '0;
            mask_page <= '0;
            mask_vld  <= 1'b0;
        end else if (wr_ok) begin
            case (reg_sel_e'(sel))
                SEL_BASE: begin
                    base_page <= wdata[PA_W-1:PAGE_LSB];
                    base_type <= wdata[MT_W-1:0];
                end
                SEL_MASK: begin
                    mask_page <= wdata[PA_W-1:PAGE_LSB];
                    mask_vld  <= wdata[VALID_BIT];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_sel_e'(sel))
            SEL_BASE: begin
                rdata[PA_W-1:PAGE_LSB] = base_page;
                rdata[MT_W-1:0]        = base_type;
            end
            SEL_MASK: begin
                rdata[PA_W-1:PAGE_LSB] = mask_page;
                rdata[VALID_BIT]       = mask_vld;
            end
            SEL_CAP:  rdata = cap_value();
            default:  rdata = '0;
        endcase
    end

    logic [PG_W-1:0] unused_pg;
    assign unused_pg = '0;

endmodule

// File: rtl/prot_range_match.sv
module prot_range_match
    import prot_range_pkg::*;
#(
    parameter int PA_W = 36
) (
    input  logic [PA_W-1:0]          addr,
    input  logic [PA_W-PAGE_LSB-1:0] base_page,
    input  logic [PA_W-PAGE_LSB-1:0] mask_page,
    input  logic                     mask_vld,
    output logic                     hit
);
    localparam int PG_W = PA_W - PAGE_LSB;

    logic [PG_W-1:0] addr_page;
    logic [PG_W-1:0] bit_miss;
    logic            unused_offs;

    assign addr_page   = addr[PA_W-1:PAGE_LSB];
    assign unused_offs = ^addr[PAGE_LSB-1:0];

    for (genvar i = 0; i < PG_W; i++) begin : g_bit
        assign bit_miss[i] = mask_page[i] & (addr_page[i] ^ base_page[i]);
    end

    assign hit = mask_vld & ~(|bit_miss);

endmodule

// File: rtl/prot_range_resolve.sv
module prot_range_resolve
    import prot_range_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              priv_mode,
    input  logic              hit,
    input  logic [MT_W-1:0]   gen_mtype,
    input  logic [MT_W-1:0]   win_mtype,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              fwd_valid,
    output logic              blocked,
    output logic [MT_W-1:0]   out_mtype,
    output logic [DATA_W-1:0] rsp_rdata
);
    acc_ctx_t ctx;
    acc_dec_t dec;

    always_comb begin
        ctx.valid = req_valid;
        ctx.write = req_write;
        ctx.priv  = priv_mode;
        ctx.hit   = hit;
        dec       = decide(ctx, gen_mtype, win_mtype);
    end

    assign fwd_valid = dec.fwd;
    assign blocked   = dec.blocked;
    assign out_mtype = dec.mtype;
    assign rsp_rdata = dec.subst ? {DATA_W{1'b1}} : mem_rdata;

endmodule

// File: rtl/prot_range_filter.sv
module prot_range_filter
    import prot_range_pkg::*;
#(
    parameter int PA_W   = 36,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              priv_mode,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [PA_W-1:0]   req_addr,
    input  logic [7:0]        gen_mtype,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              fwd_valid,
    output logic              blocked,
    output logic              in_range,
    output logic [7:0]        out_mtype,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_sel,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata
);
    localparam int PG_W = PA_W - PAGE_LSB;

    logic [PG_W-1:0] base_page;
    logic [PG_W-1:0] mask_page;
    logic [MT_W-1:0] base_type;
    logic            mask_vld;

    prot_range_regs #(.PA_W(PA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .priv_mode (priv_mode),
        .wr_en     (reg_wr_en),
        .sel       (reg_sel),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .base_page (base_page),
        .base_type (base_type),
        .mask_page (mask_page),
        .mask_vld  (mask_vld)
    );

    prot_range_match #(.PA_W(PA_W)) u_match (
        .addr      (req_addr),
        .base_page (base_page),
        .mask_page (mask_page),
        .mask_vld  (mask_vld),
        .hit       (in_range)
    );

    prot_range_resolve #(.DATA_W(DATA_W)) u_resolve (
        .req_valid (req_valid),
        .req_write (req_write),
        .priv_mode (priv_mode),
        .hit       (in_range),
        .gen_mtype (gen_mtype),
        .win_mtype (base_type),
        .mem_rdata (mem_rdata),
        .fwd_valid (fwd_valid),
        .blocked   (blocked),
        .out_mtype (out_mtype),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: rtl/prot_range_checker.sv
module prot_range_checker #(
    parameter int PA_W   = 36,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              priv_mode,
    input logic              req_valid,
    input logic              req_write,
    input logic [7:0]        gen_mtype,
    input logic [DATA_W-1:0] mem_rdata,
    input logic              fwd_valid,
    input logic              blocked,
    input logic              in_range,
    input logic [7:0]        out_mtype,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              reg_wr_en,
    input logic [1:0]        reg_sel,
    input logic [63:0]       reg_wdata,
    input logic [63:0]       reg_rdata,
    input logic [7:0]        base_type,
    input logic              mask_vld,
    input logic [PA_W-13:0]  base_page,
    input logic [PA_W-13:0]  mask_page
);
    // R3: privileged hit uses window type and proceeds
    a_r3_priv_hit: assert property (@(posedge clk) disable iff (rst)
        (req_valid && in_range && priv_mode) |-> (fwd_valid && !blocked && out_mtype == base_type));

    // R4: unprivileged read hit is stopped and returns ones
    a_r4_read_ones: assert property (@(posedge clk) disable iff (rst)
        (req_valid && in_range && !priv_mode && !req_write) |->
            (!fwd_valid && rsp_rdata == {DATA_W{1'b1}} && out_mtype == 8'd0));

    // R5: unprivileged write hit never reaches memory
    a_r5_write_drop: assert property (@(posedge clk) disable iff (rst)
        (req_valid && in_range && !priv_mode && req_write) |-> (!fwd_valid && blocked && out_mtype == 8'd0));

    // R6: miss passes everything through
    a_r6_miss_pass: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !in_range) |-> (fwd_valid && !blocked && out_mtype == gen_mtype && rsp_rdata == mem_rdata));

    // R7: accepted base write visible after one edge
    a_r7_base_update: assert property (@(posedge clk) disable iff (rst)
        (priv_mode && reg_wr_en && reg_sel == 2'd0) |=> (base_type == $past(reg_wdata[7:0])));

    // R8: no register change without privilege
    a_r8_locked: assert property (@(posedge clk) disable iff (rst)
        (!priv_mode) |=> ($stable(base_page) && $stable(mask_page) && $stable(base_type) && $stable(mask_vld)));

    // R9: capability constant
    a_r9_cap_const: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == 2'd2) |-> (reg_rdata == 64'h800));

    // R10: disabled window never hits
    a_r10_no_hit_when_off: assert property (@(posedge clk) disable iff (rst)
        (!mask_vld) |-> (!in_range));

endmodule

bind prot_range_filter prot_range_checker #(.PA_W(PA_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .priv_mode (priv_mode),
    .req_valid (req_valid),
    .req_write (req_write),
    .gen_mtype (gen_mtype),
    .mem_rdata (mem_rdata),
    .fwd_valid (fwd_valid),
    .blocked   (blocked),
    .in_range  (in_range),
    .out_mtype (out_mtype),
    .rsp_rdata (rsp_rdata),
    .reg_wr_en (reg_wr_en),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .base_type (base_type),
    .mask_vld  (mask_vld),
    .base_page (base_page),
    .mask_page (mask_page)
);

// File: tb/tb_prot_range_filter.sv
module tb_prot_range_filter;
    localparam int CLK_PERIOD = 10;
    localparam int PA_W   = 36;
    localparam int DATA_W = 64;
    localparam logic [63:0] MEM_PAT  = 64'hA5A5_5A5A_1234_8765;
    localparam logic [63:0] BASE_CFG = 64'h0000_0001_2340_0006;
    localparam logic [63:0] MASK_CFG = 64'h0000_000F_FFF0_0800;

    typedef struct packed {
        logic        priv;
        logic        wr;
        logic [35:0] addr;
        logic [7:0]  gen;
        logic        e_fwd;
        logic        e_blk;
        logic [7:0]  e_mt;
        logic        e_ones;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 36'h1_2340_0000, 8'd0, 1'b1, 1'b0, 8'd6, 1'b0}, // R3
        '{1'b1, 1'b1, 36'h1_234F_FFF8, 8'd5, 1'b1, 1'b0, 8'd6, 1'b0}, // R3
        '{1'b0, 1'b0, 36'h1_2345_6780, 8'd6, 1'b0, 1'b1, 8'd0, 1'b1}, // R4
        '{1'b0, 1'b1, 36'h1_2340_0040, 8'd6, 1'b0, 1'b1, 8'd0, 1'b0}, // R5
        '{1'b0, 1'b0, 36'h1_2350_0000, 8'd4, 1'b1, 1'b0, 8'd4, 1'b0}, // R6
        '{1'b1, 1'b0, 36'h1_233F_FFF8, 8'd1, 1'b1, 1'b0, 8'd1, 1'b0}, // R6
        '{1'b0, 1'b1, 36'h0_0000_1000, 8'd6, 1'b1, 1'b0, 8'd6, 1'b0}, // R6
        '{1'b0, 1'b0, 36'hF_2340_0000, 8'd0, 1'b1, 1'b0, 8'd0, 1'b0}  // R2
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              priv_mode = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [PA_W-1:0]   req_addr = '0;
    logic [7:0]        gen_mtype = '0;
    logic [DATA_W-1:0] mem_rdata = MEM_PAT;
    logic              fwd_valid;
    logic              blocked;
    logic              in_range;
    logic [7:0]        out_mtype;
    logic [DATA_W-1:0] rsp_rdata;
    logic              reg_wr_en = 1'b0;
    logic [1:0]        reg_sel = 2'd0;
    logic [63:0]       reg_wdata = '0;
    logic [63:0]       reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prot_range_filter #(.PA_W(PA_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst(rst), .priv_mode(priv_mode), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .gen_mtype(gen_mtype),
        .mem_rdata(mem_rdata), .fwd_valid(fwd_valid), .blocked(blocked),
        .in_range(in_range), .out_mtype(out_mtype), .rsp_rdata(rsp_rdata),
        .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic priv, input logic [1:0] sel, input logic [63:0] d);
        @(negedge clk);
        priv_mode = priv; reg_sel = sel; reg_wdata = d; reg_wr_en = 1'b1;
        @(posedge clk);
        #1;
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] sel, output logic [63:0] v);
        @(negedge clk);
        reg_sel = sel;
        #2;
        v = reg_rdata;
    endtask

    task automatic access(input logic priv, input logic wr, input logic [35:0] a, input logic [7:0] g);
        @(negedge clk);
        priv_mode = priv; req_write = wr; req_addr = a; gen_mtype = g; req_valid = 1'b1;
        #2;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        reg_read(2'd0, v); check("R1 base after reset", v, 64'h0);
        reg_read(2'd1, v); check("R1 mask after reset", v, 64'h0);
        access(1'b0, 1'b0, 36'h1_2340_0000, 8'd6);
        check("R1 fwd when disabled", {63'd0, fwd_valid}, 64'd1);
        check("R1 type passes", {56'd0, out_mtype}, 64'd6);

        // R7: write timing, old value before edge, new after
        @(negedge clk);
        req_valid = 1'b0;
        priv_mode = 1'b1; reg_sel = 2'd0; reg_wdata = BASE_CFG; reg_wr_en = 1'b1;
        #2 check("R7 base old before edge", reg_rdata, 64'h0);
        @(posedge clk);
        #1 reg_wr_en = 1'b0;
        check("R7 base new after edge", reg_rdata, BASE_CFG);
        reg_write(1'b1, 2'd1, MASK_CFG);
        reg_read(2'd1, v); check("R7 mask written", v, MASK_CFG);

        // table walk
        for (int i = 0; i < NV; i++) begin
            access(VECS[i].priv, VECS[i].wr, VECS[i].addr, VECS[i].gen);
            check($sformatf("R2-R6 vec%0d fwd", i), {63'd0, fwd_valid}, {63'd0, VECS[i].e_fwd});
            check($sformatf("R4 R5 vec%0d blocked", i), {63'd0, blocked}, {63'd0, VECS[i].e_blk});
            check($sformatf("R3 vec%0d mtype", i), {56'd0, out_mtype}, {56'd0, VECS[i].e_mt});
            if (!VECS[i].wr)
                check($sformatf("R4 R6 vec%0d rdata", i), rsp_rdata,
                      VECS[i].e_ones ? {DATA_W{1'b1}} : MEM_PAT);
        end

        // R5: no valid, nothing forwarded or blocked
        access(1'b0, 1'b1, 36'h1_2340_0000, 8'd6);
        @(negedge clk); req_valid = 1'b0; #2;
        check("R5 idle no fwd", {63'd0, fwd_valid}, 64'd0);
        check("R5 idle no block", {63'd0, blocked}, 64'd0);

        // R8: unprivileged writes ignored
        reg_write(1'b0, 2'd0, 64'h0);
        reg_write(1'b0, 2'd1, 64'h0);
        reg_read(2'd0, v); check("R8 base kept", v, BASE_CFG);
        reg_read(2'd1, v); check("R8 mask kept", v, MASK_CFG);
        access(1'b0, 1'b1, 36'h1_2340_0000, 8'd6);
        check("R8 window still guards", {63'd0, blocked}, 64'd1);

        // R9: capability and unused select
        reg_read(2'd2, v); check("R9 cap value", v, 64'h800);
        reg_write(1'b1, 2'd2, 64'h0);
        reg_read(2'd2, v); check("R9 cap after write", v, 64'h800);
        reg_write(1'b1, 2'd3, '1);
        reg_read(2'd3, v); check("R9 sel3 reads zero", v, 64'h0);
        reg_read(2'd0, v); check("R9 base untouched by sel3", v, BASE_CFG);

        // R10: valid bit clear disables the window
        reg_write(1'b1, 2'd1, 64'h0000_000F_FFF0_0000);
        access(1'b0, 1'b0, 36'h1_2340_0000, 8'd5);
        check("R10 no hit", {63'd0, in_range}, 64'd0);
        check("R10 fwd", {63'd0, fwd_valid}, 64'd1);
        check("R10 gen type", {56'd0, out_mtype}, 64'd5);
        check("R10 mem data", rsp_rdata, MEM_PAT);

        // R11: field layout
        reg_write(1'b1, 2'd0, '1);
        reg_read(2'd0, v); check("R11 base fields", v, 64'h0000_000F_FFFF_F0FF);
        reg_write(1'b1, 2'd1, '1);
        reg_read(2'd1, v); check("R11 mask fields", v, 64'h0000_000F_FFFF_F800);

        // R2: full mask, single page window, page offset ignored
        reg_write(1'b1, 2'd0, 64'h0000_0000_0007_7004);
        access(1'b1, 1'b0, 36'h0_0007_7FFF, 8'd0);
        check("R2 offset ignored hit", {63'd0, in_range}, 64'd1);
        check("R3 WT type", {56'd0, out_mtype}, 64'd4);
        access(1'b1, 1'b0, 36'h0_0007_8000, 8'd0);
        check("R2 next page miss", {63'd0, in_range}, 64'd0);

        // R1: reset clears configuration
        @(negedge clk); req_valid = 1'b0; rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        reg_read(2'd1, v); check("R1 mask cleared by reset", v, 64'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule